// File: doc/BRIEF.md
# I2C Slave Address Detector

This block is the slave-side receive front end of an I2C port. It brings the SCL and SDA lines into the core clock domain and finds START and STOP conditions, including a repeated START in the middle of a transfer. It then shifts in the first byte after each START and decides whether to answer. The address field is the upper seven bits of that byte, and the block compares it with a programmable own address. The all-zero write byte (general call) is recognised and flagged on its own output. When free-format mode is on, the block accepts any first byte and raises a dedicated pulse without checking the address.

Once a first byte is accepted, the block pulls SDA low for the acknowledge clock. Bit 0 of that byte selects the data phase. With a 0 the block acts as a slave receiver: it shifts in each byte, acknowledges it and pulses reception complete. With a 1 it acts as a slave transmitter: it sends the byte on `tx_data_i` and stops when the master does not acknowledge. The block drives SDA only through an open-drain enable. SCL is never driven.

Top module: `i2c_addr_det`

## Requirements
- R1: When bits 7:1 of the first byte after a START equal `own_addr_i` and the byte is not 0x00, `addr_match_o` pulses for one cycle and SDA is held low while SCL is high in the ninth clock.
- R2: A first byte that is neither accepted nor a general call gets no acknowledge, no pulse, and `sda_oe_o` stays low through all following clocks until the next START.
- R3: A first byte of 0x00 pulses `gen_call_o`, not `addr_match_o`, is acknowledged, and is followed by a receive data phase.
- R4: With `free_fmt_i` high, any first byte pulses `first_byte_o` and is acknowledged. `addr_match_o` stays low unless the address also matches.
- R5: After an accepted first byte, `dir_tx_o` equals bit 0 of that byte (1 = slave transmitter, 0 = slave receiver).
- R6: In receive mode, each byte is shifted in MSB first on SCL rising edges. Then `rx_data_o` holds the byte, `rx_done_o` pulses once and the block acknowledges in the ninth clock.
- R7: In transmit mode, the block sends `tx_data_i` MSB first, with SDA changing only while SCL is low, and releases SDA in the ninth clock. If the master does not acknowledge, SDA stays released from then on.
- R8: A repeated START during a data phase starts address capture again, and the new first byte is judged afresh.
- R9: A STOP, even one in the middle of the address, releases SDA and returns the block to idle. A later START is then handled normally.
- R10: In reset, `sda_oe_o`, `dir_tx_o`, all pulse outputs and `rx_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr_i | input | 7 | Programmable own address |
| free_fmt_i | input | 1 | Accept any first byte |
| tx_data_i | input | 8 | Byte to send in transmit mode |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| dir_tx_o | output | 1 | Direction of current transfer, 1 = slave transmits |
| addr_match_o | output | 1 | Own-address match pulse |
| gen_call_o | output | 1 | General call pulse |
| first_byte_o | output | 1 | Free-format first byte pulse |
| rx_done_o | output | 1 | Data byte received pulse |
| rx_data_o | output | 8 | Last received data byte |

## Verification
The hardest situations to reach from the ports are a repeated START that arrives while the block is in a receive data phase, and a STOP that cuts the address byte after only four bits. The bench drives an open-drain bus model in which the line is the wired-AND of the master's level and the block's enable. A scripted master emits these irregular conditions between ordinary bytes. A behavioural model predicts the acknowledge bits, the read-back bytes and the pulse counts. A cycle counter of `sda_oe_o` over the non-matching transfer and after a master NACK shows that SDA is never driven there.

// File: rtl/i2c_addr_det_pkg.sv
package i2c_addr_det_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } state_e;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '1;
      else         ff <= {ff[STAGES-2:0], d_i[l]};
    end
    assign q_o[l] = ff[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // SDA edge while SCL stays high
  assign start_o = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o  = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int AW = 7
) (
  input  logic [AW:0]   byte_i,
  input  logic [AW-1:0] own_i,
  input  logic          free_i,
  output logic          own_hit_o,
  output logic          gc_hit_o,
  output logic          accept_o
);
  assign gc_hit_o  = (byte_i == '0);
  assign own_hit_o = (byte_i[AW:1] == own_i) && !gc_hit_o;
  assign accept_o  = own_hit_o | gc_hit_o | free_i;
endmodule

// File: rtl/i2c_addr_det.sv
module i2c_addr_det
  import i2c_addr_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              free_fmt_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              sda_oe_o,
  output logic              dir_tx_o,
  output logic              addr_match_o,
  output logic              gen_call_o,
  output logic              first_byte_o,
  output logic              rx_done_o,
  output logic [BYTE_W-1:0] rx_data_o
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ALL_BITS = CW'(BYTE_W);

  logic [1:0] sync_q;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic own_hit, gc_hit, accept;

  state_e            state;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg, byte_nxt;
  logic              ack_on;

  i2c_in_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2c_bus_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign byte_nxt = {shreg[BYTE_W-2:0], sda_s};

  i2c_addr_cmp #(.AW(ADDR_W)) u_cmp (
    .byte_i(byte_nxt), .own_i(own_addr_i), .free_i(free_fmt_i),
    .own_hit_o(own_hit), .gc_hit_o(gc_hit), .accept_o(accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      ack_on       <= 1'b0;
      sda_oe_o     <= 1'b0;
      dir_tx_o     <= 1'b0;
      addr_match_o <= 1'b0;
      gen_call_o   <= 1'b0;
      first_byte_o <= 1'b0;
      rx_done_o    <= 1'b0;
      rx_data_o    <= '0;
    end else begin
      addr_match_o <= 1'b0;
      gen_call_o   <= 1'b0;
      first_byte_o <= 1'b0;
      rx_done_o    <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        ack_on   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        ack_on   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise) begin
            shreg <= byte_nxt;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              addr_match_o <= own_hit;
              gen_call_o   <= gc_hit;
              first_byte_o <= free_fmt_i;
              if (accept) begin
                dir_tx_o <= byte_nxt[0];
                state    <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK, ST_RACK: if (scl_fall) begin
            if (!ack_on) begin
              sda_oe_o <= 1'b1;
              ack_on   <= 1'b1;
            end else begin
              ack_on <= 1'b0;
              cnt    <= '0;
              if (state == ST_AACK && dir_tx_o) begin
                state    <= ST_TX;
                shreg    <= tx_data_i;
                sda_oe_o <= ~tx_data_i[BYTE_W-1];
              end else begin
                state    <= ST_RX;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_RX: if (scl_rise) begin
            shreg <= byte_nxt;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              rx_data_o <= byte_nxt;
              rx_done_o <= 1'b1;
              state     <= ST_RACK;
            end
          end
          ST_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            else if (scl_fall) begin
              if (cnt == ALL_BITS) begin
                sda_oe_o <= 1'b0;
                state    <= ST_TACK;
              end else begin
                sda_oe_o <= ~shreg[BYTE_W-2];
                shreg    <= shreg << 1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              if (sda_s) state <= ST_IDLE;  // master NACK
              else       ack_on <= 1'b1;
            end else if (scl_fall && ack_on) begin
              ack_on   <= 1'b0;
              cnt      <= '0;
              shreg    <= tx_data_i;
              sda_oe_o <= ~tx_data_i[BYTE_W-1];
              state    <= ST_TX;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  p_match_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |-> $past(own_hit));
  p_gc_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_call_o |-> !dir_tx_o);
  p_oe_on_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));
  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
endmodule

// File: tb/i2c_addr_det_tb.sv
module i2c_addr_det_tb;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own = 7'h5A;
  logic free_fmt = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, dir_tx, am, gc, fb, rxd;
  logic [7:0] rx_data;
  wire sda_line = m_sda & ~sda_oe;

  int errs = 0, checks = 0;
  int n_am = 0, n_gc = 0, n_fb = 0, n_rx = 0, n_oe = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_addr_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .own_addr_i(own), .free_fmt_i(free_fmt), .tx_data_i(tx_data),
    .sda_oe_o(sda_oe), .dir_tx_o(dir_tx), .addr_match_o(am),
    .gen_call_o(gc), .first_byte_o(fb), .rx_done_o(rxd), .rx_data_o(rx_data)
  );

  always @(negedge clk) begin
    if (am) n_am++;
    if (gc) n_gc++;
    if (fb) n_fb++;
    if (rxd) n_rx++;
    if (sda_oe) n_oe++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; w(Q); scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(2);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); ack = sda_line; w(Q); scl = 1'b0; w(2);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1; b = '0;
    for (int i = 0; i < 8; i++) begin
      w(Q); scl = 1'b1; w(Q); b = {b[6:0], sda_line}; w(Q); scl = 1'b0; w(2);
    end
    m_sda = mack; w(Q); scl = 1'b1; w(2 * Q); scl = 1'b0; w(2); m_sda = 1'b1;
  endtask

  // behavioural model of the accept decision
  function automatic bit model_accept(input logic [7:0] b);
    return (b[7:1] == own) || (b == 8'h00) || free_fmt;
  endfunction

  initial begin
    logic ack;
    logic [7:0] rb;
    int am0, gc0, fb0, rx0;
    w(3);
    // R10 reset state
    chk("R10 oe", sda_oe, 0);
    chk("R10 pulses", {am, gc, fb, rxd}, 0);
    chk("R10 dir/data", {dir_tx, rx_data}, 0);
    rst_n = 1'b1; w(5);

    // R1/R5/R6 own address write
    do_start();
    write_byte({own, 1'b0}, ack);
    chk("R1 ack", ack, model_accept({own, 1'b0}) ? 0 : 1);
    chk("R1 match count", n_am, 1);
    chk("R5 dir rx", dir_tx, 0);
    write_byte(8'h3C, ack);
    chk("R6 ack", ack, 0);
    chk("R6 data", rx_data, 8'h3C);
    write_byte(8'hA5, ack);
    chk("R6 data2", rx_data, 8'hA5);
    chk("R6 done count", n_rx, 2);
    do_stop(); w(5);
    chk("R9 oe after stop", sda_oe, 0);

    // R2 mismatch
    am0 = n_am; rx0 = n_rx; n_oe = 0;
    do_start();
    write_byte(8'h44, ack);
    chk("R2 nack", ack, 1);
    write_byte(8'h00, ack);
    chk("R2 data nack", ack, 1);
    chk("R2 oe cycles", n_oe, 0);
    chk("R2 pulses", n_am - am0 + n_rx - rx0 + n_gc + n_fb, 0);
    do_stop();

    // R3 general call
    am0 = n_am; rx0 = n_rx;
    do_start();
    write_byte(8'h00, ack);
    chk("R3 ack", ack, 0);
    chk("R3 gc count", n_gc, 1);
    chk("R3 no match", n_am - am0, 0);
    write_byte(8'h77, ack);
    chk("R3 rx data", rx_data, 8'h77);
    chk("R3 rx done", n_rx - rx0, 1);
    do_stop();

    // R5/R7 slave transmitter
    do_start();
    tx_data = 8'hC3;
    write_byte({own, 1'b1}, ack);
    chk("R7 addr ack", ack, 0);
    chk("R5 dir tx", dir_tx, 1);
    read_byte(1'b0, rb);
    chk("R7 byte1", rb, 8'hC3);
    tx_data = 8'h5E;
    read_byte(1'b1, rb);
    chk("R7 byte2", rb, 8'h5E);
    n_oe = 0;
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    chk("R7 released after nack", n_oe, 0);
    do_stop();

    // R8 repeated start from receive phase
    am0 = n_am;
    do_start();
    write_byte({own, 1'b0}, ack);
    write_byte(8'h11, ack);
    chk("R8 rx before rs", rx_data, 8'h11);
    do_start();
    tx_data = 8'h96;
    write_byte({own, 1'b1}, ack);
    chk("R8 ack", ack, 0);
    chk("R8 match count", n_am - am0, 2);
    chk("R8 dir", dir_tx, 1);
    read_byte(1'b1, rb);
    chk("R8 byte", rb, 8'h96);
    do_stop();

    // R4 free format
    free_fmt = 1'b1; am0 = n_am; fb0 = n_fb; rx0 = n_rx;
    do_start();
    write_byte(8'h44, ack);
    chk("R4 ack", ack, model_accept(8'h44) ? 0 : 1);
    chk("R4 first count", n_fb - fb0, 1);
    chk("R4 no match", n_am - am0, 0);
    write_byte(8'h99, ack);
    chk("R4 data", rx_data, 8'h99);
    chk("R4 rx done", n_rx - rx0, 1);
    do_stop();
    free_fmt = 1'b0;

    // R9 stop inside address, then normal transfer
    am0 = n_am; gc0 = n_gc;
    do_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    do_stop(); w(5);
    chk("R9 oe mid addr", sda_oe, 0);
    chk("R9 no pulse", n_am - am0 + n_gc - gc0, 0);
    do_start();
    write_byte({own, 1'b0}, ack);
    chk("R9 ack after", ack, 0);
    chk("R9 match after", n_am - am0, 1);
    do_stop();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule